// File: doc/BRIEF.md
# Real-time clock timer

This block is a register-mapped real-time clock. It keeps three time bases, all driven by tick enables that are synchronous to the bus clock. The first is a 32-bit seconds counter with a match alarm. The second is a 16-bit countdown wake-up timer that steps at 1 kHz. The third is a 15-bit sub-second counter that steps at 32.768 kHz. A prescaler divides the fast tick by a parameter (32768 by default) to make the one-second tick. That one-second tick advances the seconds counter, and it also marks the boundary where the sub-second counter starts and wraps.

Software controls the block through a simple synchronous register port: address, write data, write strobe, read strobe and registered read data.

- The alarm and wake-up conditions each set a sticky flag. Software clears a flag by writing a one to its bit.
- Each flag drives an interrupt line.
- A second pair of outputs asks the system to leave deep power-down. Each of these is the flag gated by its own enable bit.
- A software reset bit holds the whole block at its reset values and blocks every other write.
- The two oscillator control bits are only stored and driven out on pins.

Register offsets: control 0x00, match 0x04, seconds 0x08, wake-up timer 0x0C, sub-second 0x10.

Control register bits:

| Bit | Name | Access |
|-----|------|--------|
| 0 | soft_rst | read-write |
| 1 | (none) | always reads 0 |
| 2 | alarm_flag | write-one-to-clear |
| 3 | wake_flag | write-one-to-clear |
| 4 | alarm_dpd_en | read-write |
| 5 | wake_dpd_en | read-write |
| 6 | khz_en | read-write |
| 7 | run_en | read-write |
| 8 | osc_pd | read-write |
| 9 | osc_byp | read-write |
| 10 | sub_en | read-write |

Top module: `rtc_core`

## Requirements
- R1: After `rst`, every register reads 0 and `alarm_irq`, `wake_irq`, `alarm_wake_dpd`, `timer_wake_dpd`, `osc_pd` and `osc_bypass` are 0.
- R2: Control bits 4, 5, 6, 8 and 9 read back as written. Bit 1 always reads 0. `osc_pd` follows bit 8 and `osc_bypass` follows bit 9.
- R3: While run_en (bit 7) is 1, the seconds counter (0x08) adds 1 on every PRESCALE-th `tick_32k` pulse. The count of pulses starts at zero when run_en is set, so the first increment comes a full second after enabling.
- R4: A write to 0x08 loads the seconds counter only while run_en is 0. While run_en is 1, the write is ignored.
- R5: While run_en is 1 and the seconds counter equals the match register (0x04), alarm_flag (bit 2) is set. `alarm_irq` equals alarm_flag.
- R6: Writing 1 to bit 2 clears alarm_flag. Writing 0 leaves it unchanged. A set condition in the same cycle wins over the clear.
- R7: A write to 0x0C loads the wake-up count, and a read returns the current count.
  - The count steps down by 1 on each permitted `tick_1k` pulse and stops at 0.
  - wake_flag (bit 3) is set once, on the step from 1 to 0.
  - `wake_irq` equals wake_flag, and writing 1 to bit 3 clears it.
- R8: The wake-up count steps only when both khz_en (bit 6) and run_en are 1. Otherwise it holds its value.
- R9: The sub-second counter (0x10) is 0 while sub_en (bit 10) is 0.
  - After sub_en is set, the counter stays at 0 until the next one-second tick.
  - It then adds 1 per `tick_32k` pulse and returns to 0 on each one-second tick.
- R10: Writing 1 to sub_en takes effect only if run_en was already 1 before the write and the same write keeps bit 7 at 1. Clearing run_en also clears sub_en.
- R11: While soft_rst (bit 0) is 1:
  - every other register bit and counter is held at 0;
  - writes to 0x04, 0x08 and 0x0C have no effect;
  - a control write changes only bit 0.
  Writing 1 to bit 0 clears all state at the same edge.
- R12: `alarm_wake_dpd` equals alarm_flag AND alarm_dpd_en (bit 4). `timer_wake_dpd` equals wake_flag AND wake_dpd_en (bit 5).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and timer clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe; data appears on `bus_rdata` one cycle later |
| bus_rdata | output | 32 | Registered read data |
| tick_32k | input | 1 | 32.768 kHz tick enable, one clock wide |
| tick_1k | input | 1 | 1 kHz tick enable, one clock wide |
| alarm_irq | output | 1 | Alarm interrupt request (alarm_flag) |
| wake_irq | output | 1 | Wake-up timer interrupt request (wake_flag) |
| alarm_wake_dpd | output | 1 | Deep power-down exit request from the alarm |
| timer_wake_dpd | output | 1 | Deep power-down exit request from the wake-up timer |
| osc_pd | output | 1 | Stored oscillator power-down bit |
| osc_bypass | output | 1 | Stored oscillator bypass bit |

## Verification
The assertions check the following on every cycle:
- The seconds counter never moves by more than one step, unless a load or soft reset is legal in that cycle, and a write to it while running never lands.
- The wake-up count holds while the run bit is off.
- sub_en is never 1 without run_en.
- The sub-second counter is zero whenever sub_en is off.
- soft_rst empties every counter.

Only the bench scenarios can show the timing relations:
- the first increment comes exactly one full second after enabling;
- the sub-second counter waits for the next second boundary and wraps at it;
- the wake flag is raised a single time at the end of a countdown of a given length;
- write-one-to-clear against a still-true alarm compare;
- a control write made during soft reset is blocked.

// File: rtl/rtc_core_pkg.sv
package rtc_core_pkg;

  localparam int unsigned OFS_CTRL  = 'h00;
  localparam int unsigned OFS_MATCH = 'h04;
  localparam int unsigned OFS_SEC   = 'h08;
  localparam int unsigned OFS_WAKE  = 'h0C;
  localparam int unsigned OFS_SUB   = 'h10;

  localparam int unsigned B_SWRST = 0;
  localparam int unsigned B_AFLAG = 2;
  localparam int unsigned B_WFLAG = 3;
  localparam int unsigned B_ADPD  = 4;
  localparam int unsigned B_WDPD  = 5;
  localparam int unsigned B_KHZ   = 6;
  localparam int unsigned B_RUN   = 7;
  localparam int unsigned B_OPD   = 8;
  localparam int unsigned B_OBYP  = 9;
  localparam int unsigned B_SUBEN = 10;

  localparam int unsigned NUM_FLAGS = 2;
  localparam int unsigned FLAG_ALARM = 0;
  localparam int unsigned FLAG_WAKE  = 1;

  typedef struct packed {
    logic sub_en;
    logic osc_byp;
    logic osc_pd;
    logic run_en;
    logic khz_en;
    logic wake_dpd_en;
    logic alarm_dpd_en;
  } cfg_t;

  function automatic int unsigned flag_bit(input int unsigned idx);
    return (idx == FLAG_ALARM) ? B_AFLAG : B_WFLAG;
  endfunction

endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
  parameter int unsigned PRESCALE = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  input  logic tick_in,
  output logic tick_out
);
  localparam int unsigned PS_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [PS_W-1:0] LAST = PS_W'(PRESCALE - 1);

  logic [PS_W-1:0] cnt_q;

  // Phase restarts whenever the time base is stopped, so a fresh enable
  // waits a full PRESCALE ticks before its first one-second pulse.
  always_ff @(posedge clk) begin
    if (rst || clr || !run) begin
      cnt_q <= '0;
    end else if (tick_in) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign tick_out = run && tick_in && (cnt_q == LAST);

endmodule

// File: rtl/rtc_subsec.sv
module rtc_subsec #(
  parameter int unsigned SUB_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick_fast,
  input  logic             tick_sec,
  output logic [SUB_W-1:0] cnt
);
  logic armed_q;
  logic [SUB_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (tick_sec) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (armed_q && tick_fast) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/rtc_wake.sv
module rtc_wake #(
  parameter int unsigned WAKE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              load,
  input  logic [WAKE_W-1:0] load_val,
  input  logic              step,
  output logic [WAKE_W-1:0] cnt,
  output logic              expire
);
  localparam logic [WAKE_W-1:0] ONE = WAKE_W'(1);

  logic [WAKE_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (step && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt    = cnt_q;
  assign expire = step && !load && !clr && (cnt_q == ONE);

endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_core_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned SEC_W    = 32,
  parameter int unsigned WAKE_W   = 16,
  parameter int unsigned SUB_W    = 15,
  parameter int unsigned PRESCALE = 32768
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  input  logic              tick_32k,
  input  logic              tick_1k,
  output logic              alarm_irq,
  output logic              wake_irq,
  output logic              alarm_wake_dpd,
  output logic              timer_wake_dpd,
  output logic              osc_pd,
  output logic              osc_bypass
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_MATCH = ADDR_W'(OFS_MATCH);
  localparam logic [ADDR_W-1:0] A_SEC   = ADDR_W'(OFS_SEC);
  localparam logic [ADDR_W-1:0] A_WAKE  = ADDR_W'(OFS_WAKE);
  localparam logic [ADDR_W-1:0] A_SUB   = ADDR_W'(OFS_SUB);

  logic                 swrst_q;
  cfg_t                 cfg_q;
  logic [NUM_FLAGS-1:0] flag_q;
  logic [NUM_FLAGS-1:0] flag_set;
  logic [SEC_W-1:0]     sec_q;
  logic [SEC_W-1:0]     match_q;
  logic [WAKE_W-1:0]    wake_cnt;
  logic [SUB_W-1:0]     sub_cnt;
  logic                 tick_sec;
  logic                 wake_expire;

  // Write decode
  logic wr_ctrl, wr_match, wr_sec, wr_wake;
  assign wr_ctrl  = bus_we && (bus_addr == A_CTRL);
  assign wr_match = bus_we && (bus_addr == A_MATCH);
  assign wr_sec   = bus_we && (bus_addr == A_SEC);
  assign wr_wake  = bus_we && (bus_addr == A_WAKE);

  // Clears all state now: held soft reset, or a write that asserts it.
  logic soft_clr;
  assign soft_clr = swrst_q || (wr_ctrl && bus_wdata[B_SWRST]);

  // Control, match and seconds registers
  always_ff @(posedge clk) begin
    if (rst) begin
      swrst_q <= 1'b0;
      cfg_q   <= '0;
      sec_q   <= '0;
      match_q <= '0;
    end else if (soft_clr) begin
      // During soft reset only bit 0 of a control write is honoured.
      if (wr_ctrl) begin
        swrst_q <= bus_wdata[B_SWRST];
      end
      cfg_q   <= '0;
      sec_q   <= '0;
      match_q <= '0;
    end else begin
      if (wr_ctrl) begin
        cfg_q.alarm_dpd_en <= bus_wdata[B_ADPD];
        cfg_q.wake_dpd_en  <= bus_wdata[B_WDPD];
        cfg_q.khz_en       <= bus_wdata[B_KHZ];
        cfg_q.run_en       <= bus_wdata[B_RUN];
        cfg_q.osc_pd       <= bus_wdata[B_OPD];
        cfg_q.osc_byp      <= bus_wdata[B_OBYP];
        cfg_q.sub_en       <= bus_wdata[B_SUBEN] && bus_wdata[B_RUN] && cfg_q.run_en;
      end
      if (wr_match) begin
        match_q <= bus_wdata[SEC_W-1:0];
      end
      if (wr_sec && !cfg_q.run_en) begin
        sec_q <= bus_wdata[SEC_W-1:0];
      end else if (tick_sec) begin
        sec_q <= sec_q + 1'b1;
      end
    end
  end

  // Sticky write-one-to-clear flags; a set event wins over a clear.
  assign flag_set[FLAG_ALARM] = cfg_q.run_en && (sec_q == match_q);
  assign flag_set[FLAG_WAKE]  = wake_expire;

  for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
    logic clr_ev;
    assign clr_ev = wr_ctrl && bus_wdata[flag_bit(gi)];
    always_ff @(posedge clk) begin
      if (rst || soft_clr) begin
        flag_q[gi] <= 1'b0;
      end else begin
        flag_q[gi] <= flag_set[gi] || (flag_q[gi] && !clr_ev);
      end
    end
  end

  // Time bases
  rtc_tick_div #(.PRESCALE(PRESCALE)) u_div (
    .clk      (clk),
    .rst      (rst),
    .clr      (soft_clr),
    .run      (cfg_q.run_en),
    .tick_in  (tick_32k),
    .tick_out (tick_sec)
  );

  rtc_subsec #(.SUB_W(SUB_W)) u_sub (
    .clk       (clk),
    .rst       (rst),
    .clr       (soft_clr || !cfg_q.sub_en),
    .tick_fast (tick_32k),
    .tick_sec  (tick_sec),
    .cnt       (sub_cnt)
  );

  rtc_wake #(.WAKE_W(WAKE_W)) u_wake (
    .clk      (clk),
    .rst      (rst),
    .clr      (soft_clr),
    .load     (wr_wake),
    .load_val (bus_wdata[WAKE_W-1:0]),
    .step     (tick_1k && cfg_q.run_en && cfg_q.khz_en),
    .cnt      (wake_cnt),
    .expire   (wake_expire)
  );

  // Registered read path
  logic [31:0] ctrl_view;
  always_comb begin
    ctrl_view          = '0;
    ctrl_view[B_SWRST] = swrst_q;
    ctrl_view[B_AFLAG] = flag_q[FLAG_ALARM];
    ctrl_view[B_WFLAG] = flag_q[FLAG_WAKE];
    ctrl_view[B_ADPD]  = cfg_q.alarm_dpd_en;
    ctrl_view[B_WDPD]  = cfg_q.wake_dpd_en;
    ctrl_view[B_KHZ]   = cfg_q.khz_en;
    ctrl_view[B_RUN]   = cfg_q.run_en;
    ctrl_view[B_OPD]   = cfg_q.osc_pd;
    ctrl_view[B_OBYP]  = cfg_q.osc_byp;
    ctrl_view[B_SUBEN] = cfg_q.sub_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_re) begin
      case (bus_addr)
        A_CTRL:  bus_rdata <= ctrl_view;
        A_MATCH: bus_rdata <= 32'(match_q);
        A_SEC:   bus_rdata <= 32'(sec_q);
        A_WAKE:  bus_rdata <= 32'(wake_cnt);
        A_SUB:   bus_rdata <= 32'(sub_cnt);
        default: bus_rdata <= '0;
      endcase
    end
  end

  // Outputs straight from flops (dpd outputs are an AND of two flops)
  assign alarm_irq      = flag_q[FLAG_ALARM];
  assign wake_irq       = flag_q[FLAG_WAKE];
  assign alarm_wake_dpd = flag_q[FLAG_ALARM] && cfg_q.alarm_dpd_en;
  assign timer_wake_dpd = flag_q[FLAG_WAKE] && cfg_q.wake_dpd_en;
  assign osc_pd         = cfg_q.osc_pd;
  assign osc_bypass     = cfg_q.osc_byp;

endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned WAKE_W = 16,
  parameter int unsigned SUB_W  = 15
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_we,
  input logic              swrst_q,
  input logic              run_en,
  input logic              sub_en,
  input logic [SEC_W-1:0]  sec_q,
  input logic [SEC_W-1:0]  match_q,
  input logic [WAKE_W-1:0] wake_cnt,
  input logic [SUB_W-1:0]  sub_cnt,
  input logic              wake_irq
);
  logic ctrl_wr, sec_wr, wake_wr;
  assign ctrl_wr = bus_we && (bus_addr == ADDR_W'(8'h00));
  assign sec_wr  = bus_we && (bus_addr == ADDR_W'(8'h08));
  assign wake_wr = bus_we && (bus_addr == ADDR_W'(8'h0C));

  // R11: a held soft reset leaves every counter and the match value at zero
  assert_swrst_clears_R11: assert property (@(posedge clk) disable iff (rst)
    swrst_q |=> (sec_q == '0 && match_q == '0 && wake_cnt == '0 && sub_cnt == '0));

  // R3: seconds move by at most one step when nothing may load or clear them
  assert_sec_single_step_R3: assert property (@(posedge clk) disable iff (rst)
    (!swrst_q && !ctrl_wr && !sec_wr) |=>
      (sec_q == $past(sec_q) || sec_q == $past(sec_q) + 1'b1));

  // R4: a seconds write while running does not land
  assert_sec_write_locked_R4: assert property (@(posedge clk) disable iff (rst)
    (sec_wr && run_en && !swrst_q) |=>
      (sec_q == $past(sec_q) || sec_q == $past(sec_q) + 1'b1));

  // R10: sub-second enable never stands without the run bit
  assert_sub_needs_run_R10: assert property (@(posedge clk) disable iff (rst)
    sub_en |-> run_en);

  // R9: sub-second counter is empty whenever its enable is low
  assert_sub_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !sub_en |=> (sub_cnt == '0));

  // R7: the wake flag rises only when the countdown has reached zero
  assert_wake_flag_at_zero_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_irq) |-> (wake_cnt == '0));

  // R8: the wake count is frozen while the run bit is off
  assert_wake_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !wake_wr && !ctrl_wr && !swrst_q) |=> $stable(wake_cnt));

endmodule

bind rtc_core rtc_core_chk #(
  .ADDR_W(ADDR_W), .SEC_W(SEC_W), .WAKE_W(WAKE_W), .SUB_W(SUB_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_we    (bus_we),
  .swrst_q   (swrst_q),
  .run_en    (cfg_q.run_en),
  .sub_en    (cfg_q.sub_en),
  .sec_q     (sec_q),
  .match_q   (match_q),
  .wake_cnt  (wake_cnt),
  .sub_cnt   (sub_cnt),
  .wake_irq  (wake_irq)
);

// File: tb/sim_rtc_core.sv
module sim_rtc_core;
  localparam int unsigned PS = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        tick_32k = 1'b0, tick_1k = 1'b0;
  logic        alarm_irq, wake_irq, alarm_wake_dpd, timer_wake_dpd, osc_pd, osc_bypass;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  rtc_core #(.PRESCALE(PS)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .tick_32k(tick_32k), .tick_1k(tick_1k), .alarm_irq(alarm_irq),
    .wake_irq(wake_irq), .alarm_wake_dpd(alarm_wake_dpd),
    .timer_wake_dpd(timer_wake_dpd), .osc_pd(osc_pd), .osc_bypass(osc_bypass)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    rv = bus_rdata;
  endtask

  task automatic t32(input int n);
    for (int i = 0; i < n; i++) begin
      tick_32k = 1'b1;
      @(negedge clk);
      tick_32k = 1'b0;
    end
  endtask

  task automatic t1k(input int n);
    for (int i = 0; i < n; i++) begin
      tick_1k = 1'b1;
      @(negedge clk);
      tick_1k = 1'b0;
    end
  endtask

  // Expected control word from the documented bit positions.
  function automatic logic [31:0] ctrl_word(input bit sub, input bit run, input bit khz,
                                            input bit wdpd, input bit adpd,
                                            input bit wflag, input bit aflag);
    return (32'(sub) << 10) | (32'(run) << 7) | (32'(khz) << 6) | (32'(wdpd) << 5) |
           (32'(adpd) << 4) | (32'(wflag) << 3) | (32'(aflag) << 2);
  endfunction

  bit finished = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int          wn;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a <= 16; a += 4) begin
      rd(8'(a));
      chk("R1 reg reset", rv, 32'h0);
    end
    chk("R1 outputs", {26'b0, alarm_irq, wake_irq, alarm_wake_dpd, timer_wake_dpd, osc_pd, osc_bypass}, 32'h0);

    // R2 plain control bits, bit 1 reads zero
    wr(8'h00, 32'h0000_0332);
    rd(8'h00);
    chk("R2 ctrl readback", rv, 32'h0000_0330);
    chk("R2 osc pins", {30'b0, osc_pd, osc_bypass}, 32'h3);
    wr(8'h00, 32'h0);

    // R4 load while stopped
    v = $urandom & 32'h0FFF_FFFF;
    wr(8'h08, v);
    rd(8'h08);
    chk("R4 load stopped", rv, v);
    wr(8'h04, v + 32'd3);

    // R10 sub enable without earlier run
    wr(8'h00, 32'h0000_0480);
    rd(8'h00);
    chk("R10 sub needs prior run", rv, ctrl_word(0, 1, 0, 0, 0, 0, 0));

    // R4 write while running ignored
    wr(8'h08, v + 32'd100);
    rd(8'h08);
    chk("R4 write ignored running", rv, v);

    // R3 first increment a full second after enable
    t32(PS - 1);
    rd(8'h08);
    chk("R3 before first second", rv, v);
    t32(1);
    rd(8'h08);
    chk("R3 first second", rv, v + 32'd1);

    // R10 / R9 sub-second start at next boundary
    wr(8'h00, 32'h0000_0480);
    rd(8'h00);
    chk("R10 sub set after run", rv, ctrl_word(1, 1, 0, 0, 0, 0, 0));
    t32(5);
    rd(8'h10);
    chk("R9 waits for boundary", rv, 32'h0);
    t32(PS - 5);
    rd(8'h08);
    chk("R3 second two", rv, v + 32'd2);
    t32(7);
    rd(8'h10);
    chk("R9 counting", rv, 32'd7);
    t32(PS - 7);
    rd(8'h10);
    chk("R9 wrap at second", rv, 32'h0);

    // R5 alarm at match
    chk("R5 alarm_irq", 32'(alarm_irq), 32'd1);
    rd(8'h00);
    chk("R5 alarm flag bit", rv, ctrl_word(1, 1, 0, 0, 0, 0, 1));
    chk("R12 alarm dpd gated off", 32'(alarm_wake_dpd), 32'd0);

    // R6 writing 0 keeps flag; R12 gate on
    wr(8'h00, 32'h0000_0490);
    chk("R6 write zero no clear", 32'(alarm_irq), 32'd1);
    chk("R12 alarm dpd", 32'(alarm_wake_dpd), 32'd1);
    t32(PS);
    wr(8'h00, 32'h0000_0494);
    chk("R6 write one clears", 32'(alarm_irq), 32'd0);
    chk("R12 alarm dpd follows", 32'(alarm_wake_dpd), 32'd0);

    // R7 wake countdown
    wr(8'h00, 32'h0000_04D0);
    wn = 3 + int'($urandom % 18);
    wr(8'h0C, 32'(wn));
    t1k(wn - 1);
    rd(8'h0C);
    chk("R7 count near end", rv, 32'd1);
    chk("R7 no early flag", 32'(wake_irq), 32'd0);
    t1k(1);
    rd(8'h0C);
    chk("R7 at zero", rv, 32'd0);
    chk("R7 wake_irq", 32'(wake_irq), 32'd1);
    t1k(3);
    rd(8'h0C);
    chk("R7 stops at zero", rv, 32'd0);
    wr(8'h00, 32'h0000_04D8);
    t1k(3);
    chk("R7 flag raised once", 32'(wake_irq), 32'd0);

    // R12 wake dpd
    wr(8'h00, 32'h0000_04F0);
    wr(8'h0C, 32'd2);
    t1k(2);
    chk("R12 timer dpd", 32'(timer_wake_dpd), 32'd1);

    // R8 gating by khz enable and by run
    wr(8'h00, 32'h0000_04A8);
    chk("R12 timer dpd cleared", 32'(timer_wake_dpd), 32'd0);
    wr(8'h0C, 32'd10);
    t1k(4);
    rd(8'h0C);
    chk("R8 khz off holds", rv, 32'd10);
    wr(8'h00, 32'h0000_0460);
    rd(8'h00);
    chk("R10 run clear drops sub", rv, ctrl_word(0, 0, 1, 1, 0, 0, 0));
    t1k(4);
    rd(8'h0C);
    chk("R8 run off holds", rv, 32'd10);
    rd(8'h10);
    chk("R9 zero when disabled", rv, 32'h0);

    // R11 soft reset
    wr(8'h00, 32'h0000_0001);
    rd(8'h00);
    chk("R11 ctrl in reset", rv, 32'h1);
    rd(8'h08);
    chk("R11 seconds cleared", rv, 32'h0);
    rd(8'h0C);
    chk("R11 wake cleared", rv, 32'h0);
    wr(8'h04, 32'h77);
    rd(8'h04);
    chk("R11 match write blocked", rv, 32'h0);
    wr(8'h00, 32'h0000_00F0);
    rd(8'h00);
    chk("R11 release changes only bit0", rv, 32'h0);

    // Random alarm scenarios (R3, R5)
    for (int it = 0; it < 4; it++) begin
      int k;
      v = $urandom;
      k = 1 + int'($urandom % 3);
      wr(8'h08, v);
      wr(8'h04, v + 32'(k));
      wr(8'h00, 32'h80);
      t32(PS * k - 1);
      chk("R5 random no early alarm", 32'(alarm_irq), 32'd0);
      t32(1);
      rd(8'h08);
      chk("R3 random seconds", rv, v + 32'(k));
      chk("R5 random alarm", 32'(alarm_irq), 32'd1);
      wr(8'h00, 32'h1);
      wr(8'h00, 32'h0);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule